// File: doc/BRIEF.md
# Interrupt Request Capture and In-Service Latch

This block captures raw interrupt request lines for an interrupt controller and keeps the in-service record. Each line can be set to edge or level sensitivity through a trigger-select register. A level-sensitive line's pending bit simply mirrors its input. An edge-sensitive line sets its pending bit on a low-to-high transition, detected against a registered copy of the previous input level, and keeps that bit until the line is acknowledged.

A priority resolver outside the block issues an acknowledge strobe together with the index of the line it picked. On that acknowledge the block does three things. It drops the pending bit, but only for an edge-sensitive line. It marks the line in service, unless automatic end-of-interrupt is selected. When automatic end-of-interrupt is combined with rotation, it moves the rotation offset to the line after the one acknowledged. End-of-interrupt commands reach the block as a vector of in-service bits to clear. The set of lines that may be switched to level sensitivity is fixed by a parameter mask.

Top module: `irq_req_latch`

## Requirements
- R1: After reset, the pending, last-level, in-service and trigger-select vectors are zero (all lines edge-sensitive), and the rotation offset is 0.
- R2: For a line whose trigger-select bit is 1 (level), the pending bit after a clock edge equals the input level sampled at that edge. An acknowledge does not clear it.
- R3: For a line whose trigger-select bit is 0 (edge), the pending bit becomes 1 when the input is 1 and the last-level bit is 0, unless that line is acknowledged in the same cycle.
- R4: For an edge line, the pending bit keeps its value while the input is low or stays high, unless the line is acknowledged.
- R5: An acknowledge of line k clears pending bit k only when trigger-select bit k is 0.
- R6: An acknowledge of line k with automatic end-of-interrupt off sets in-service bit k.
- R7: An acknowledge with automatic end-of-interrupt on sets no in-service bit. If rotation is also on, the rotation offset becomes (k+1) mod N. In every other case the offset holds its value.
- R8: Each 1 in the in-service clear vector clears that in-service bit at the next edge. A set from an acknowledge of the same line takes precedence.
- R9: A trigger-select write stores the data ANDed with the parameter LEVEL_OK, so lines outside LEVEL_OK always read back 0.
- R10: Every last-level bit equals the input level sampled at the previous edge, whatever the trigger mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NLINES | Raw request levels, synchronous to clk |
| trig_we | input | 1 | Trigger-select write enable |
| trig_wdata | input | NLINES | Trigger-select write data, 1 = level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDXW | Index of the acknowledged line |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| rot_on_aeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| isr_clr | input | NLINES | In-service bits to clear |
| irr | output | NLINES | Pending request vector |
| isr | output | NLINES | In-service vector |
| last_lvl | output | NLINES | Registered previous input levels |
| trig_sel | output | NLINES | Trigger-select vector |
| rot_off | output | IDXW | Rotation offset |

## Verification
The hardest cases to reach are the collisions on a single line in a single cycle. Examples are a rising edge that arrives together with that line's acknowledge, or an in-service clear that coincides with an in-service set. Uniform random stimulus hits these only rarely. The stimulus therefore narrows the acknowledge index and the clear vector to a few lines that it also toggles hard, and adds directed cycles for each collision. A reference model in the bench follows every cycle.

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NLINES = 8,
  parameter int IDXW = $clog2(NLINES),
  parameter logic [NLINES-1:0] LEVEL_OK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_in,
  input  logic              trig_we,
  input  logic [NLINES-1:0] trig_wdata,
  input  logic              ack_valid,
  input  logic [IDXW-1:0]   ack_line,
  input  logic              auto_eoi,
  input  logic              rot_on_aeoi,
  input  logic [NLINES-1:0] isr_clr,
  output logic [NLINES-1:0] irr,
  output logic [NLINES-1:0] isr,
  output logic [NLINES-1:0] last_lvl,
  output logic [NLINES-1:0] trig_sel,
  output logic [IDXW-1:0]   rot_off
);

  function automatic logic [IDXW-1:0] wrap_inc(input logic [IDXW-1:0] k);
    return (int'(k) == NLINES - 1) ? '0 : k + 1'b1;
  endfunction

  logic [NLINES-1:0] ack_hot;
  logic [NLINES-1:0] irr_nxt;
  logic [NLINES-1:0] isr_set;

  assign ack_hot = ack_valid ? (NLINES'(1) << ack_line) : '0;
  assign isr_set = auto_eoi ? '0 : ack_hot;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic cap;
    assign cap = trig_sel[i] ? req_in[i]
                             : (irr[i] | (req_in[i] & ~last_lvl[i]));
    assign irr_nxt[i] = cap & ~(ack_hot[i] & ~trig_sel[i]);

    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(trig_sel[i]) |-> irr[i] == $past(req_in[i]));
    p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!trig_sel[i] && req_in[i] && !last_lvl[i] &&
                            !(ack_valid && ack_line == IDXW'(i))) |-> irr[i]);
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!trig_sel[i] && !(ack_valid && ack_line == IDXW'(i)) &&
                            (!req_in[i] || last_lvl[i])) |-> irr[i] == $past(irr[i]));
    p_isr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(isr_clr[i] && !(ack_valid && !auto_eoi && ack_line == IDXW'(i)))
      |-> !isr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr      <= '0;
      isr      <= '0;
      last_lvl <= '0;
      trig_sel <= '0;
      rot_off  <= '0;
    end else begin
      irr      <= irr_nxt;
      last_lvl <= req_in;
      isr      <= (isr & ~isr_clr) | isr_set;
      if (trig_we) trig_sel <= trig_wdata & LEVEL_OK;
      if (ack_valid && auto_eoi && rot_on_aeoi) rot_off <= wrap_inc(ack_line);
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (irr == '0 && isr == '0 && last_lvl == '0) || rst_n);
  p_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> last_lvl == $past(req_in));
  p_ack_edge_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ack_valid && !trig_sel[ack_line]) |-> !irr[$past(ack_line)]);
  p_ack_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ack_valid && !auto_eoi) |-> isr[$past(ack_line)]);
  p_aeoi_rot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ack_valid && auto_eoi && rot_on_aeoi)
    |-> rot_off == wrap_inc($past(ack_line)));
  p_rot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(ack_valid && auto_eoi && rot_on_aeoi) |-> $stable(rot_off));
  p_trig_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel & ~LEVEL_OK) == '0);

endmodule

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
  localparam int N = 8;
  localparam logic [N-1:0] OKM = 8'h3F;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_in = 0, trig_wdata = 0, isr_clr = 0;
  logic trig_we = 0, ack_valid = 0, auto_eoi = 0, rot_on_aeoi = 0;
  logic [2:0] ack_line = 0;
  logic [N-1:0] irr, isr, last_lvl, trig_sel;
  logic [2:0] rot_off;

  logic [N-1:0] m_irr = 0, m_isr = 0, m_last = 0, m_trig = 0;
  logic [2:0] m_rot = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_req_latch #(.NLINES(N), .LEVEL_OK(OKM)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_we(trig_we),
    .trig_wdata(trig_wdata), .ack_valid(ack_valid), .ack_line(ack_line),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .isr_clr(isr_clr),
    .irr(irr), .isr(isr), .last_lvl(last_lvl), .trig_sel(trig_sel),
    .rot_off(rot_off));

  task automatic chk(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "irr", int'(irr), int'(m_irr));
    chk(tag, "isr", int'(isr), int'(m_isr));
    chk({tag, " R10"}, "last_lvl", int'(last_lvl), int'(m_last));
    chk(tag, "trig_sel", int'(trig_sel), int'(m_trig));
    chk(tag, "rot_off", int'(rot_off), int'(m_rot));
  endtask

  task automatic model_step();
    logic [N-1:0] ni = m_irr, ns;
    for (int i = 0; i < N; i++) begin
      if (m_trig[i]) ni[i] = req_in[i];
      else if (req_in[i] && !m_last[i]) ni[i] = 1'b1;
    end
    ns = m_isr & ~isr_clr;
    if (ack_valid) begin
      if (!m_trig[ack_line]) ni[ack_line] = 1'b0;
      if (!auto_eoi) ns[ack_line] = 1'b1;
      else if (rot_on_aeoi) m_rot = ack_line + 3'd1;
    end
    if (trig_we) m_trig = trig_wdata & OKM;
    m_irr = ni; m_isr = ns; m_last = req_in;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    check_all(tag);
    ack_valid = 0; trig_we = 0; isr_clr = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    trig_we = 1; trig_wdata = 8'hFF; tick("R9 masked write");
    trig_we = 1; trig_wdata = 8'h01; tick("R9 rewrite");

    req_in = 8'h01; tick("R2 level high");
    ack_valid = 1; ack_line = 0; tick("R2 R5 ack level kept");
    req_in = 8'h00; tick("R2 level low");

    req_in = 8'h02; tick("R3 edge rise");
    tick("R4 held high");
    req_in = 8'h00; tick("R4 low keeps pending");
    ack_valid = 1; ack_line = 1; tick("R5 R6 ack edge");
    isr_clr = 8'h02; tick("R8 eoi clear");

    req_in = 8'h04; ack_valid = 1; ack_line = 2; tick("R3 R5 rise with ack");
    isr_clr = 8'h04; ack_valid = 1; ack_line = 2; tick("R8 set beats clear");
    auto_eoi = 1; rot_on_aeoi = 1; ack_valid = 1; ack_line = 7; tick("R7 rotate wrap");
    ack_valid = 1; ack_line = 3; tick("R7 rotate");
    rot_on_aeoi = 0; ack_valid = 1; ack_line = 5; tick("R7 no rotate no isr");
    auto_eoi = 0;

    for (int n = 0; n < 3000; n++) begin
      req_in = (n % 3 == 0) ? $urandom : (req_in ^ (N'(1) << ($urandom % 3)));
      ack_valid = ($urandom % 3) == 0;
      ack_line = 3'($urandom % ((n % 2) ? 8 : 3));
      auto_eoi = ($urandom % 4) == 0;
      rot_on_aeoi = $urandom % 2;
      isr_clr = ($urandom % 2) ? N'($urandom % 8) : N'($urandom);
      trig_we = ($urandom % 16) == 0;
      trig_wdata = $urandom;
      tick("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule